// File: doc/BRIEF.md
# Exception Return Control Unit

This block decodes and carries out the return-from-exception instruction for a 32-bit-encoded RISC core that has a system-control coprocessor. On each cycle it looks at one instruction word with its valid strobe and a flag that marks a branch delay slot. It also looks at the current Status register and at the two 64-bit saved-PC registers: the normal exception PC and the error PC. When the word is a legal return, the block produces these results one cycle later: a redirect to the saved address, a new Status value with the right level bit cleared, and a flush of the instruction that follows. The return has no delay slot, which is why that flush is needed.

The error-level bit picks the source of the return address and the Status bit that is cleared. When compressed instructions are enabled, the low bit of the saved address does not go into the PC. It goes into an ISA-mode flag that the block holds. The block raises a reserved-instruction flag when the return sits in a delay slot. It raises a coprocessor-unusable flag when the core lacks the privilege to run it. In both cases it changes no state.

Top module: `eret_ctrl`

## Requirements
- R1: An instruction is a return only when `instr_valid_i` is 1 and `instr_i` equals 0x42000018. That value has bits 31:26 = 010000, bit 25 = 1, bits 24:6 = 0 and bits 5:0 = 011000. Any other word, or valid low, leaves every strobe and flag low. It also leaves `redirect_pc_o` and `status_o` at zero in the following cycle.
- R2: When Status bit 2 (error level) is 1, the return address comes from `error_epc_i`. `status_o` equals the input Status with only bit 2 cleared.
- R3: When Status bit 2 is 0, the return address comes from `epc_i`. `status_o` equals the input Status with only bit 1 (exception level) cleared.
- R4: When `cmp_isa_en_i` is 1, `redirect_pc_o` is the selected register with bit 0 forced to 0. `isa_mode_o` takes that register's bit 0.
- R5: When `cmp_isa_en_i` is 0, `redirect_pc_o` is the full selected register. `isa_mode_o` keeps its value.
- R6: `redirect_o`, `status_we_o` and `flush_o` are high together for exactly the one cycle after each accepted legal return, and are low otherwise.
- R7: A return with `in_delay_slot_i` = 1 sets `rsvd_instr_o` for one cycle. It causes no redirect, no Status write and no change to `isa_mode_o`.
- R8: The instruction may run when Status bit 2 is 1, or Status bit 1 is 1, or Status bits 4:3 = 00, or Status bit 28 is 1. Otherwise it sets `cop_unusable_o` for one cycle and changes nothing. A delay-slot violation takes priority over this check.
- R9: `rsvd_instr_o`, `cop_unusable_o` and `redirect_o` are mutually exclusive.
- R10: While `rst_ni` is low, and after reset, all strobes and flags are low and `isa_mode_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| instr_i | input | 32 | Instruction word |
| in_delay_slot_i | input | 1 | Instruction occupies a branch delay slot |
| status_i | input | 32 | Current Status register |
| epc_i | input | 64 | Saved exception PC |
| error_epc_i | input | 64 | Saved error PC |
| cmp_isa_en_i | input | 1 | Compressed instruction set enabled |
| redirect_o | output | 1 | Take redirect to `redirect_pc_o` |
| redirect_pc_o | output | 64 | Return address |
| status_we_o | output | 1 | Write `status_o` into Status |
| status_o | output | 32 | Updated Status value |
| isa_mode_o | output | 1 | Current ISA-mode flag |
| flush_o | output | 1 | Flush the instruction after the return |
| rsvd_instr_o | output | 1 | Reserved-instruction exception |
| cop_unusable_o | output | 1 | Coprocessor-unusable exception |

## Verification
The hardest case to reach is an ISA-mode flag that must stay the same across returns made with compressed mode disabled. The flag is only visible after an earlier return has set it. For that reason the stimulus first performs a compressed-mode return from an odd address, and then issues returns with compression off, with a delay-slot violation, and with an unusable coprocessor. A behavioural model in the bench tracks the flag across the whole run. The privilege rule is covered by walking the mode field through every value, with and without the level bits and the coprocessor-usable bit. A long random phase mixes legal words, words one bit away from legal, and random Status values.

// File: rtl/eret_pkg.sv
package eret_pkg;
  parameter int unsigned ILEN = 32;

  localparam int unsigned OPC_MSB = ILEN - 1;
  localparam int unsigned OPC_LSB = ILEN - 6;
  localparam int unsigned CO_BIT  = ILEN - 7;
  localparam int unsigned FN_W    = 6;

  localparam logic [5:0] OPC_SYSCOP = 6'b010000;
  localparam logic [5:0] FN_RETURN  = 6'b011000;

  typedef enum logic [1:0] {
    ACT_NONE     = 2'd0,
    ACT_RETURN   = 2'd1,
    ACT_RSVD     = 2'd2,
    ACT_UNUSABLE = 2'd3
  } eret_act_e;
endpackage

// File: rtl/eret_decode.sv
module eret_decode
  import eret_pkg::*;
#(
  parameter int unsigned SR_W     = 32,
  parameter int unsigned ERL_BIT  = 2,
  parameter int unsigned EXL_BIT  = 1,
  parameter int unsigned MODE_LSB = 3,
  parameter int unsigned CU0_BIT  = 28
) (
  input  logic             valid_i,
  input  logic [ILEN-1:0]  instr_i,
  input  logic             in_ds_i,
  input  logic [SR_W-1:0]  status_i,
  output eret_act_e        act_o
);
  localparam int unsigned ZERO_W = CO_BIT - FN_W;

  logic opc_hit, co_hit, zero_hit, fn_hit, match;
  logic kernel, usable;

  always_comb begin
    opc_hit  = instr_i[OPC_MSB:OPC_LSB] == OPC_SYSCOP;
    co_hit   = instr_i[CO_BIT];
    zero_hit = instr_i[CO_BIT-1:FN_W] == {ZERO_W{1'b0}};
    fn_hit   = instr_i[FN_W-1:0] == FN_RETURN;
    match    = opc_hit && co_hit && zero_hit && fn_hit;
  end

  // kernel: any level bit set, or mode field zero
  always_comb begin
    kernel = status_i[ERL_BIT] || status_i[EXL_BIT] ||
             (status_i[MODE_LSB+1:MODE_LSB] == 2'b00);
    usable = kernel || status_i[CU0_BIT];
  end

  always_comb begin
    act_o = ACT_NONE;
    if (valid_i && match) begin
      if (in_ds_i)      act_o = ACT_RSVD;
      else if (!usable) act_o = ACT_UNUSABLE;
      else              act_o = ACT_RETURN;
    end
  end
endmodule

// File: rtl/eret_target_sel.sv
module eret_target_sel #(
  parameter int unsigned XLEN = 64
) (
  input  logic            erl_i,
  input  logic            cmp_en_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] error_epc_i,
  output logic [XLEN-1:0] pc_o,
  output logic            isa_bit_o,
  output logic            isa_we_o
);
  logic [XLEN-1:0] src;

  always_comb begin
    src       = erl_i ? error_epc_i : epc_i;
    isa_bit_o = src[0];
    isa_we_o  = cmp_en_i;
    pc_o      = cmp_en_i ? {src[XLEN-1:1], 1'b0} : src;
  end
endmodule

// File: rtl/eret_status_upd.sv
module eret_status_upd #(
  parameter int unsigned SR_W    = 32,
  parameter int unsigned ERL_BIT = 2,
  parameter int unsigned EXL_BIT = 1
) (
  input  logic [SR_W-1:0] status_i,
  output logic [SR_W-1:0] status_o
);
  logic [SR_W-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (status_i[ERL_BIT]) clr_mask[ERL_BIT] = 1'b1;
    else                   clr_mask[EXL_BIT] = 1'b1;
    status_o = status_i & ~clr_mask;
  end
endmodule

// File: rtl/eret_ctrl.sv
module eret_ctrl
  import eret_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned SR_W     = 32,
  parameter int unsigned ERL_BIT  = 2,
  parameter int unsigned EXL_BIT  = 1,
  parameter int unsigned MODE_LSB = 3,
  parameter int unsigned CU0_BIT  = 28
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            instr_valid_i,
  input  logic [ILEN-1:0] instr_i,
  input  logic            in_delay_slot_i,
  input  logic [SR_W-1:0] status_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] error_epc_i,
  input  logic            cmp_isa_en_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            status_we_o,
  output logic [SR_W-1:0] status_o,
  output logic            isa_mode_o,
  output logic            flush_o,
  output logic            rsvd_instr_o,
  output logic            cop_unusable_o
);
  eret_act_e       act;
  logic [XLEN-1:0] tgt_pc;
  logic            tgt_isa, tgt_isa_we;
  logic [SR_W-1:0] sr_next;
  logic            do_ret;

  eret_decode #(
    .SR_W(SR_W), .ERL_BIT(ERL_BIT), .EXL_BIT(EXL_BIT),
    .MODE_LSB(MODE_LSB), .CU0_BIT(CU0_BIT)
  ) u_dec (
    .valid_i (instr_valid_i),
    .instr_i (instr_i),
    .in_ds_i (in_delay_slot_i),
    .status_i(status_i),
    .act_o   (act)
  );

  eret_target_sel #(.XLEN(XLEN)) u_tgt (
    .erl_i      (status_i[ERL_BIT]),
    .cmp_en_i   (cmp_isa_en_i),
    .epc_i      (epc_i),
    .error_epc_i(error_epc_i),
    .pc_o       (tgt_pc),
    .isa_bit_o  (tgt_isa),
    .isa_we_o   (tgt_isa_we)
  );

  eret_status_upd #(.SR_W(SR_W), .ERL_BIT(ERL_BIT), .EXL_BIT(EXL_BIT)) u_sr (
    .status_i(status_i),
    .status_o(sr_next)
  );

  assign do_ret = act == ACT_RETURN;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o     <= 1'b0;
      redirect_pc_o  <= '0;
      status_we_o    <= 1'b0;
      status_o       <= '0;
      flush_o        <= 1'b0;
      rsvd_instr_o   <= 1'b0;
      cop_unusable_o <= 1'b0;
      isa_mode_o     <= 1'b0;
    end else begin
      redirect_o     <= do_ret;
      status_we_o    <= do_ret;
      flush_o        <= do_ret;
      redirect_pc_o  <= do_ret ? tgt_pc : '0;
      status_o       <= do_ret ? sr_next : '0;
      rsvd_instr_o   <= act == ACT_RSVD;
      cop_unusable_o <= act == ACT_UNUSABLE;
      if (do_ret && tgt_isa_we) isa_mode_o <= tgt_isa;
    end
  end

  // R1
  strobe_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o || rsvd_instr_o || cop_unusable_o) |-> $past(instr_valid_i));
  // R9
  exc_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({redirect_o, rsvd_instr_o, cop_unusable_o}) <= 1);
  // R6
  flush_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (flush_o && status_we_o));
  // R7
  rsvd_ds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_instr_o |-> $past(in_delay_slot_i));
  // R3
  epc_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !$past(status_i[ERL_BIT]) && !$past(cmp_isa_en_i))
      |-> redirect_pc_o == $past(epc_i));
  // R2
  erl_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && $past(status_i[ERL_BIT]))
      |-> (!status_o[ERL_BIT] && status_o[EXL_BIT] == $past(status_i[EXL_BIT])));
  // R5
  isa_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(isa_mode_o) |-> ($past(cmp_isa_en_i) && redirect_o));
endmodule

// File: tb/eret_ctrl_tb.sv
module eret_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        v = 1'b0;
  logic [31:0] w = '0;
  logic        ds = 1'b0;
  logic [31:0] sr = '0;
  logic [63:0] e = '0;
  logic [63:0] ee = '0;
  logic        cmp = 1'b0;

  logic        redirect, status_we, isa_mode, flush, rsvd, unus;
  logic [63:0] rpc;
  logic [31:0] sro;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit m_isa = 0;

  localparam logic [31:0] RET_WORD = {6'b010000, 1'b1, 19'd0, 6'b011000};

  always #10 clk = ~clk;

  eret_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(v), .instr_i(w),
    .in_delay_slot_i(ds), .status_i(sr), .epc_i(e), .error_epc_i(ee),
    .cmp_isa_en_i(cmp), .redirect_o(redirect), .redirect_pc_o(rpc),
    .status_we_o(status_we), .status_o(sro), .isa_mode_o(isa_mode),
    .flush_o(flush), .rsvd_instr_o(rsvd), .cop_unusable_o(unus)
  );

  function automatic logic [169:0] pack(logic r, logic [63:0] p, logic we,
      logic [31:0] s, logic i, logic f, logic ri, logic cu);
    return {r, p, we, s, i, f, ri, cu, 68'd0};
  endfunction

  task automatic compare(string req, logic [169:0] exp);
    logic [169:0] act;
    act = pack(redirect, rpc, status_we, sro, isa_mode, flush, rsvd, unus);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act[169:68], exp[169:68]);
    end
  endtask

  // behavioural reference, then one clock, then compare
  task automatic step(string req, logic vi, logic [31:0] wi, logic dsi,
      logic [31:0] sri, logic [63:0] ei, logic [63:0] eei, logic ci);
    logic usable, hit, ret, ri, cu;
    logic [63:0] src, pc;
    logic [31:0] s;
    v = vi; w = wi; ds = dsi; sr = sri; e = ei; ee = eei; cmp = ci;
    hit = vi && (wi == RET_WORD);
    usable = sri[2] || sri[1] || (sri[4:3] == 2'b00) || sri[28];
    ri = hit && dsi;
    cu = hit && !dsi && !usable;
    ret = hit && !dsi && usable;
    src = sri[2] ? eei : ei;
    s = sri;
    if (sri[2]) s[2] = 1'b0; else s[1] = 1'b0;
    pc = src;
    if (ci) pc[0] = 1'b0;
    if (ret && ci) m_isa = src[0];
    @(posedge clk);
    @(negedge clk);
    compare(req, pack(ret, ret ? pc : 64'd0, ret, ret ? s : 32'd0, m_isa,
                      ret, ri, cu));
  endtask

  task automatic idle(string req);
    step(req, 1'b0, RET_WORD, 1'b0, 32'h2, 64'h10, 64'h20, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R10", pack(0, 0, 0, 0, 0, 0, 0, 0));
    rst_n = 1'b1;
    @(negedge clk);
    compare("R10", pack(0, 0, 0, 0, 0, 0, 0, 0));

    // R3 exception level, R5 plain address
    step("R3", 1, RET_WORD, 0, 32'h0000_0013, 64'h1234_5678_9abc_def1,
         64'hffff_0000_0000_0004, 0);
    // R2 error level
    step("R2", 1, RET_WORD, 0, 32'hf000_0016, 64'h1111_0000_0000_0008,
         64'h8000_0000_bfc0_0101, 0);
    // R4 compressed: odd address sets ISA mode
    step("R4", 1, RET_WORD, 0, 32'h0000_0002, 64'h0000_0000_8000_1235,
         64'h0, 1);
    // R5 disabled: ISA mode must hold at 1
    step("R5", 1, RET_WORD, 0, 32'h0000_0002, 64'h0000_0000_8000_2000,
         64'h0, 0);
    // R7 delay slot must not touch ISA mode
    step("R7", 1, RET_WORD, 1, 32'h0000_0002, 64'h0000_0000_4000_0000,
         64'h0, 1);
    idle("R6");
    // R4 error level, even address clears ISA mode
    step("R4", 1, RET_WORD, 0, 32'h0000_0004, 64'h1, 64'h0000_0000_9000_0010, 1);
    // R1 near misses
    step("R1", 1, RET_WORD & ~32'h0200_0000, 0, 32'h2, 64'h40, 64'h80, 0);
    step("R1", 1, RET_WORD | 32'h0000_0040, 0, 32'h2, 64'h40, 64'h80, 0);
    step("R1", 1, RET_WORD ^ 32'h0000_0001, 0, 32'h2, 64'h40, 64'h80, 0);
    step("R1", 1, RET_WORD ^ 32'h8000_0000, 0, 32'h2, 64'h40, 64'h80, 0);
    step("R1", 0, RET_WORD, 0, 32'h2, 64'h40, 64'h80, 0);
    // R8 privilege walk
    step("R8", 1, RET_WORD, 0, 32'h0000_0010, 64'h100, 64'h200, 0);
    step("R8", 1, RET_WORD, 0, 32'h0000_0008, 64'h100, 64'h200, 0);
    step("R8", 1, RET_WORD, 0, 32'h0000_0018, 64'h100, 64'h200, 0);
    step("R8", 1, RET_WORD, 0, 32'h1000_0010, 64'h100, 64'h200, 0);
    step("R8", 1, RET_WORD, 0, 32'h0000_0000, 64'h100, 64'h200, 0);
    step("R8", 1, RET_WORD, 0, 32'h0000_0014, 64'h100, 64'h300, 0);
    step("R8", 1, RET_WORD, 1, 32'h0000_0010, 64'h100, 64'h200, 0);
    // R6 back to back then idle
    step("R6", 1, RET_WORD, 0, 32'h2, 64'h500, 64'h600, 0);
    step("R6", 1, RET_WORD, 0, 32'h6, 64'h700, 64'h800, 0);
    idle("R6");
    idle("R6");

    // R9 random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] ww, ss;
      ww = RET_WORD;
      if ($urandom_range(0, 2) == 0) ww = ww ^ (32'h1 << $urandom_range(0, 31));
      if ($urandom_range(0, 9) == 0) ww = $urandom;
      ss = $urandom;
      step("R9", $urandom_range(0, 3) != 0, ww, $urandom_range(0, 7) == 0, ss,
           {$urandom, $urandom}, {$urandom, $urandom}, $urandom_range(0, 1) == 1);
    end

    rst_n = 1'b0;
    m_isa = 0;
    @(negedge clk);
    compare("R10", pack(0, 0, 0, 0, 0, 0, 0, 0));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule